// File: doc/BRIEF.md
# Dual-Output Space-Vector Segment Sequencer

This block drives the three legs of a nine-switch inverter that feeds two independent three-phase loads through shared legs. Once per switching period it takes the sector of each output's reference, four active dwell times (two per output) and the period length, all in clock cycles. It then emits, on every clock, the conduction state of each leg and the nine gate signals that follow from it. The dwell times come from an upstream modulator. This block only orders them in time and never lets both loads draw from the DC bus in the same cycle.

A period is cut into twelve segments. There are four for the upper output's two active vectors (each vector split into two halves), four for the lower output's active vectors, and four zero segments that share the leftover time. A mode input picks one of two zero-vector placements. The first keeps leg transitions few. The second puts a zero vector inside each output's active group so that each group sits around it. All inputs are captured at the start of a period. When the requested dwells do not fit, they are shrunk in proportion and a flag is raised for that period.

Leg codes used throughout: `01` = upper and mid switches on (top pair), `10` = upper and lower switches on (outer pair), `11` = mid and lower switches on (bottom pair). Leg A occupies `legState[1:0]`, leg B `[3:2]`, leg C `[5:4]`. Bit 0 of every gate vector is leg A.

Top module: `dual_svm_sequencer`

## Requirements
- R1: For every leg, the gate triple follows its code. Top pair drives upper and mid high, outer pair drives upper and lower high, bottom pair drives mid and lower high. Exactly two gates of a leg are ever high.
- R2: While reset is asserted, and until the first clock edge after its release, all three legs hold the outer pair (code 10) and `satFlag` is 0.
- R3: Each period plays twelve segments in this fixed order: upper odd half, upper even half, zero, upper even rest, upper odd rest, zero, lower odd half, lower even half, zero, lower even rest, lower odd rest, zero. A "half" is floor(t/2) and its "rest" is t minus that. The first three zero segments each last floor(Z/4) and the last one takes the remainder of Z.
- R4: Sector s (0..5) selects corner vectors E(s) and E(s+1 mod 6) from the ring 100,110,010,011,001,101 (bit 2 = leg A). T1 goes to E(sU) and T2 to E(sU+1); T3 and T4 do the same for the lower sector. In an upper-active segment a leg whose vector bit is 1 takes the outer pair and a 0 takes the bottom pair. In a lower-active segment a 1 takes the top pair and a 0 takes the outer pair.
- R5: In no cycle does any leg hold the top pair while another leg holds the bottom pair.
- R6: With `lowDistortion` = 0 all four zero segments put every leg in the outer pair. The even vector of each output stands on both sides of the zero inside that output's group.
- R7: With `lowDistortion` = 1 the zero inside the upper group puts every leg in the top pair and the zero inside the lower group puts every leg in the bottom pair. The two zeros between groups put every leg in the outer pair.
- R8: A period lasts exactly `periodLen` cycles. The total zero time Z is `periodLen` minus the sum of the applied dwells, and a segment of zero length takes no cycle.
- R9: If T1+T2+T3+T4 exceeds `periodLen`, each dwell is replaced by floor(Ti·periodLen/sum) and `satFlag` is 1 for that whole period. Otherwise dwells are used unchanged and `satFlag` is 0.
- R10: Inputs are sampled only on the clock edge that starts a period. A change in the middle of a period has no effect until the next period.
- R11: A sector value of 6 or 7 is treated as sector 0.
- R12: The even vector of an output is the one that places two legs in the outer pair, and the odd vector places one leg there. Every active segment therefore shows one or two outer-pair legs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upSector | input | 3 | Sector of the upper output's reference |
| loSector | input | 3 | Sector of the lower output's reference |
| dwellT1 | input | DW | Upper dwell for the first corner vector |
| dwellT2 | input | DW | Upper dwell for the second corner vector |
| dwellT3 | input | DW | Lower dwell for the first corner vector |
| dwellT4 | input | DW | Lower dwell for the second corner vector |
| periodLen | input | DW | Switching period in cycles (at least 1) |
| lowDistortion | input | 1 | 0 = fewest transitions, 1 = centred active groups |
| legState | output | 6 | Per-leg conduction code, leg A in bits 1:0 |
| gateUpper | output | 3 | Upper switch gate per leg |
| gateMid | output | 3 | Mid switch gate per leg |
| gateLower | output | 3 | Lower switch gate per leg |
| satFlag | output | 1 | Dwells of the current period were scaled down |

## Verification
A wrong period counter or a wrong cumulative boundary puts a segment edge one or more cycles early or late. The reference model compares every cycle, so the mismatch appears at the first cycle where the bad boundary is crossed, at the latest one period after the bad value was loaded. A mistaken vector lookup, a swapped odd/even order or a wrong zero choice shows at the ports in the first cycle of the affected segment, as a wrong leg code and gate triple. A latch that takes inputs mid-period shows as a shifted segment edge within that same period. A wrong scaling path shows as a wrong flag and wrong segment lengths across the whole overrun period.

// File: rtl/dual_svm_pkg.sv
`timescale 1ns/1ps
package dual_svm_pkg;

  localparam int SEGS = 12;

  // Leg conduction codes
  localparam logic [1:0] CODE_TOP    = 2'b01;  // upper + mid on
  localparam logic [1:0] CODE_OUTER  = 2'b10;  // upper + lower on
  localparam logic [1:0] CODE_BOTTOM = 2'b11;  // mid + lower on

  localparam logic [5:0] ALL_TOP    = {3{CODE_TOP}};
  localparam logic [5:0] ALL_OUTER  = {3{CODE_OUTER}};
  localparam logic [5:0] ALL_BOTTOM = {3{CODE_BOTTOM}};

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture inputs, new period starts on this edge
    logic running;  // a period is in progress
  } seqStrobe_t;

  function automatic logic [2:0] normSector(input logic [2:0] s);
    return (s > 3'd5) ? 3'd0 : s;
  endfunction

  function automatic logic [2:0] nextSector(input logic [2:0] s);
    return (s == 3'd5) ? 3'd0 : s + 3'd1;
  endfunction

  // Corner vector ring, bit 2 = leg A
  function automatic logic [2:0] cornerVec(input logic [2:0] s);
    case (s)
      3'd0:    return 3'b100;
      3'd1:    return 3'b110;
      3'd2:    return 3'b010;
      3'd3:    return 3'b011;
      3'd4:    return 3'b001;
      default: return 3'b101;
    endcase
  endfunction

  // Upper output active, lower output held at zero (all low)
  function automatic logic [5:0] upperLegs(input logic [2:0] v);
    logic [5:0] r;
    for (int i = 0; i < 3; i++) r[2*i +: 2] = v[2-i] ? CODE_OUTER : CODE_BOTTOM;
    return r;
  endfunction

  // Lower output active, upper output held at zero (all high)
  function automatic logic [5:0] lowerLegs(input logic [2:0] v);
    logic [5:0] r;
    for (int i = 0; i < 3; i++) r[2*i +: 2] = v[2-i] ? CODE_TOP : CODE_OUTER;
    return r;
  endfunction

endpackage

// File: rtl/dual_svm_ctrl.sv
`timescale 1ns/1ps
module dual_svm_ctrl
  import dual_svm_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] periodReg,
  output seqStrobe_t    strobe,
  output logic [DW-1:0] pos
);

  logic          running;
  logic [DW-1:0] cnt;
  logic [DW:0]   nextCnt;
  logic          wrapNow;

  assign nextCnt = {1'b0, cnt} + {{DW{1'b0}}, 1'b1};
  assign wrapNow = nextCnt >= {1'b0, periodReg};

  assign strobe.load    = !running || wrapNow;
  assign strobe.running = running;
  assign pos            = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (strobe.load) begin
      running <= 1'b1;
      cnt     <= '0;
    end else begin
      cnt <= nextCnt[DW-1:0];
    end
  end

  // Position never leaves the latched period
  assert_pos_in_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && periodReg != '0) |-> (cnt < periodReg));

  // A load always restarts the position at zero
  assert_load_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> (cnt == '0 && running));

endmodule

// File: rtl/dual_svm_datapath.sv
`timescale 1ns/1ps
module dual_svm_datapath
  import dual_svm_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seqStrobe_t    strobe,
  input  logic [DW-1:0] pos,
  input  logic [2:0]    upSector,
  input  logic [2:0]    loSector,
  input  logic [DW-1:0] dwellT1,
  input  logic [DW-1:0] dwellT2,
  input  logic [DW-1:0] dwellT3,
  input  logic [DW-1:0] dwellT4,
  input  logic [DW-1:0] periodIn,
  input  logic          modeIn,
  output logic [DW-1:0] periodReg,
  output logic [5:0]    legState,
  output logic          satFlag
);

  localparam int SW = DW + 2;
  localparam int PW = 2 * DW;

  // ---------------- dwell fitting ----------------
  logic [DW-1:0] dwIn  [4];
  logic [DW-1:0] dwFit [4];
  logic [SW-1:0] rawSum, fitSum;
  logic          overrun;
  logic [PW-1:0] divisor;

  assign dwIn[0] = dwellT1;
  assign dwIn[1] = dwellT2;
  assign dwIn[2] = dwellT3;
  assign dwIn[3] = dwellT4;

  assign rawSum  = SW'(dwellT1) + SW'(dwellT2) + SW'(dwellT3) + SW'(dwellT4);
  assign overrun = rawSum > SW'(periodIn);
  assign divisor = overrun ? PW'(rawSum) : PW'(1);

  for (genvar k = 0; k < 4; k++) begin : gFit
    logic [PW-1:0] prod;
    assign prod     = PW'(dwIn[k]) * PW'(periodIn);
    assign dwFit[k] = overrun ? DW'(prod / divisor) : dwIn[k];
  end

  assign fitSum = SW'(dwFit[0]) + SW'(dwFit[1]) + SW'(dwFit[2]) + SW'(dwFit[3]);

  logic [DW-1:0] zeroTime, zeroQuarter;
  assign zeroTime    = periodIn - DW'(fitSum);
  assign zeroQuarter = zeroTime >> 2;

  // ---------------- vector selection ----------------
  logic [2:0] sUp, sLo;
  logic [2:0] upA, upB, loA, loB;
  logic [2:0] upOddV, upEvenV, loOddV, loEvenV;
  logic [DW-1:0] upOddT, upEvenT, loOddT, loEvenT;

  assign sUp = normSector(upSector);
  assign sLo = normSector(loSector);
  assign upA = cornerVec(sUp);
  assign upB = cornerVec(nextSector(sUp));
  assign loA = cornerVec(sLo);
  assign loB = cornerVec(nextSector(sLo));

  // Upper: the two-ones corner puts two legs in the outer pair (even)
  assign upOddV  = sUp[0] ? upB : upA;
  assign upEvenV = sUp[0] ? upA : upB;
  assign upOddT  = sUp[0] ? dwFit[1] : dwFit[0];
  assign upEvenT = sUp[0] ? dwFit[0] : dwFit[1];

  // Lower: the one-one corner puts two legs in the outer pair (even)
  assign loEvenV = sLo[0] ? loB : loA;
  assign loOddV  = sLo[0] ? loA : loB;
  assign loEvenT = sLo[0] ? dwFit[3] : dwFit[2];
  assign loOddT  = sLo[0] ? dwFit[2] : dwFit[3];

  // ---------------- segment lengths and boundaries ----------------
  logic [DW-1:0] dur [SEGS];
  logic [DW-1:0] cum [SEGS];

  assign dur[0]  = upOddT >> 1;
  assign dur[1]  = upEvenT >> 1;
  assign dur[2]  = zeroQuarter;
  assign dur[3]  = upEvenT - (upEvenT >> 1);
  assign dur[4]  = upOddT - (upOddT >> 1);
  assign dur[5]  = zeroQuarter;
  assign dur[6]  = loOddT >> 1;
  assign dur[7]  = loEvenT >> 1;
  assign dur[8]  = zeroQuarter;
  assign dur[9]  = loEvenT - (loEvenT >> 1);
  assign dur[10] = loOddT - (loOddT >> 1);
  assign dur[11] = zeroTime - zeroQuarter - zeroQuarter - zeroQuarter;

  assign cum[0] = dur[0];
  for (genvar i = 1; i < SEGS; i++) begin : gCum
    assign cum[i] = cum[i-1] + dur[i];
  end

  // ---------------- period registers ----------------
  logic [DW-1:0] endReg [SEGS];
  logic [2:0]    upOddR, upEvenR, loOddR, loEvenR;
  logic          modeReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodReg <= '0;
      satFlag   <= 1'b0;
      modeReg   <= 1'b0;
      upOddR    <= '0;
      upEvenR   <= '0;
      loOddR    <= '0;
      loEvenR   <= '0;
      for (int i = 0; i < SEGS; i++) endReg[i] <= '0;
    end else if (strobe.load) begin
      periodReg <= periodIn;
      satFlag   <= overrun;
      modeReg   <= modeIn;
      upOddR    <= upOddV;
      upEvenR   <= upEvenV;
      loOddR    <= loOddV;
      loEvenR   <= loEvenV;
      for (int i = 0; i < SEGS; i++) endReg[i] <= cum[i];
    end
  end

  // ---------------- segment lookup and leg decode ----------------
  logic [3:0] segIdx;

  always_comb begin
    segIdx = '0;
    for (int i = 0; i < SEGS - 1; i++) begin
      if (endReg[i] <= pos) segIdx = segIdx + 4'd1;
    end
  end

  always_comb begin
    legState = ALL_OUTER;
    if (strobe.running) begin
      case (segIdx)
        4'd0:    legState = upperLegs(upOddR);
        4'd1:    legState = upperLegs(upEvenR);
        4'd2:    legState = modeReg ? ALL_TOP : ALL_OUTER;
        4'd3:    legState = upperLegs(upEvenR);
        4'd4:    legState = upperLegs(upOddR);
        4'd5:    legState = ALL_OUTER;
        4'd6:    legState = lowerLegs(loOddR);
        4'd7:    legState = lowerLegs(loEvenR);
        4'd8:    legState = modeReg ? ALL_BOTTOM : ALL_OUTER;
        4'd9:    legState = lowerLegs(loEvenR);
        4'd10:   legState = lowerLegs(loOddR);
        default: legState = ALL_OUTER;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [1:0] outerCount;
  logic       zeroSeg;

  always_comb begin
    outerCount = '0;
    for (int i = 0; i < 3; i++) begin
      if (legState[2*i +: 2] == CODE_OUTER) outerCount = outerCount + 2'd1;
    end
  end

  assign zeroSeg = (segIdx == 4'd2) || (segIdx == 4'd5) || (segIdx == 4'd8) || (segIdx == 4'd11);

  for (genvar i = 1; i < SEGS; i++) begin : gOrd
    assert_ends_ordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
      endReg[i-1] <= endReg[i]);
  end

  assert_period_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.running |-> (endReg[SEGS-1] == periodReg));

  assert_hold_between_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> ($stable(periodReg) && $stable(modeReg) && $stable(satFlag)));

  assert_active_parity_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.running && !zeroSeg) |-> (outerCount == 2'd1 || outerCount == 2'd2));

  assert_centred_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.running && modeReg && segIdx == 4'd2) |-> (legState == ALL_TOP));

  assert_min_switch_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.running && !modeReg && zeroSeg) |-> (legState == ALL_OUTER));

endmodule

// File: rtl/dual_svm_sequencer.sv
`timescale 1ns/1ps
module dual_svm_sequencer
  import dual_svm_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    upSector,
  input  logic [2:0]    loSector,
  input  logic [DW-1:0] dwellT1,
  input  logic [DW-1:0] dwellT2,
  input  logic [DW-1:0] dwellT3,
  input  logic [DW-1:0] dwellT4,
  input  logic [DW-1:0] periodLen,
  input  logic          lowDistortion,
  output logic [5:0]    legState,
  output logic [2:0]    gateUpper,
  output logic [2:0]    gateMid,
  output logic [2:0]    gateLower,
  output logic          satFlag
);

  seqStrobe_t    strobe;
  logic [DW-1:0] pos;
  logic [DW-1:0] periodReg;

  dual_svm_ctrl #(.DW(DW)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .periodReg (periodReg),
    .strobe    (strobe),
    .pos       (pos)
  );

  dual_svm_datapath #(.DW(DW)) path_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .pos       (pos),
    .upSector  (upSector),
    .loSector  (loSector),
    .dwellT1   (dwellT1),
    .dwellT2   (dwellT2),
    .dwellT3   (dwellT3),
    .dwellT4   (dwellT4),
    .periodIn  (periodLen),
    .modeIn    (lowDistortion),
    .periodReg (periodReg),
    .legState  (legState),
    .satFlag   (satFlag)
  );

  logic [2:0] topLeg, bottomLeg;

  for (genvar g = 0; g < 3; g++) begin : gLeg
    logic [1:0] code;
    assign code         = legState[2*g +: 2];
    assign gateUpper[g] = (code != CODE_BOTTOM);
    assign gateMid[g]   = (code != CODE_OUTER);
    assign gateLower[g] = (code != CODE_TOP);
    assign topLeg[g]    = gateUpper[g] && gateMid[g];
    assign bottomLeg[g] = gateMid[g] && gateLower[g];

    assert_two_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({gateUpper[g], gateMid[g], gateLower[g]}) == 2);
  end

  assert_single_load_on_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !((|topLeg) && (|bottomLeg)));

endmodule

// File: tb/dual_svm_sequencer_tb.sv
`timescale 1ns/1ps
module dual_svm_sequencer_tb_top;

  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    upSector = '0, loSector = '0;
  logic [DW-1:0] dwellT1 = '0, dwellT2 = '0, dwellT3 = '0, dwellT4 = '0;
  logic [DW-1:0] periodLen = 10'd12;
  logic          lowDistortion = 1'b0;
  logic [5:0]    legState;
  logic [2:0]    gateUpper, gateMid, gateLower;
  logic          satFlag;

  always #5 clk = ~clk;

  dual_svm_sequencer #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .upSector(upSector), .loSector(loSector),
    .dwellT1(dwellT1), .dwellT2(dwellT2), .dwellT3(dwellT3), .dwellT4(dwellT4),
    .periodLen(periodLen), .lowDistortion(lowDistortion),
    .legState(legState), .gateUpper(gateUpper), .gateMid(gateMid),
    .gateLower(gateLower), .satFlag(satFlag)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string tagNow = "R2";

  // ---------------- reference model ----------------
  int ring [6] = '{4, 6, 2, 3, 1, 5};  // 100,110,010,011,001,101
  int expQ [$];
  int segQ [$];
  bit started = 0;
  bit satE = 0;
  bit modeE = 0;

  function automatic int upState(int v);
    int r = 0;
    for (int i = 0; i < 3; i++) r |= ((((v >> (2 - i)) & 1) != 0) ? 2 : 3) << (2 * i);
    return r;
  endfunction

  function automatic int loState(int v);
    int r = 0;
    for (int i = 0; i < 3; i++) r |= ((((v >> (2 - i)) & 1) != 0) ? 1 : 2) << (2 * i);
    return r;
  endfunction

  task automatic buildPeriod();
    int t [4];
    int su, sl, tp, sum, z, q;
    int uOd, uEv, uOdT, uEvT, lOd, lEv, lOdT, lEvT, vA, vB;
    int d [12];
    int st [12];
    su = (upSector > 5) ? 0 : int'(upSector);
    sl = (loSector > 5) ? 0 : int'(loSector);
    t[0] = dwellT1; t[1] = dwellT2; t[2] = dwellT3; t[3] = dwellT4;
    tp = periodLen;
    sum = t[0] + t[1] + t[2] + t[3];
    satE = (sum > tp);
    modeE = lowDistortion;
    if (satE) for (int k = 0; k < 4; k++) t[k] = (t[k] * tp) / sum;
    z = tp - (t[0] + t[1] + t[2] + t[3]);
    q = z / 4;
    vA = ring[su]; vB = ring[(su + 1) % 6];
    if ($countones(vA) == 2) begin uEv = vA; uEvT = t[0]; uOd = vB; uOdT = t[1]; end
    else                     begin uOd = vA; uOdT = t[0]; uEv = vB; uEvT = t[1]; end
    vA = ring[sl]; vB = ring[(sl + 1) % 6];
    if ($countones(vA) == 1) begin lEv = vA; lEvT = t[2]; lOd = vB; lOdT = t[3]; end
    else                     begin lOd = vA; lOdT = t[2]; lEv = vB; lEvT = t[3]; end
    d = '{uOdT / 2, uEvT / 2, q, uEvT - uEvT / 2, uOdT - uOdT / 2, q,
          lOdT / 2, lEvT / 2, q, lEvT - lEvT / 2, lOdT - lOdT / 2, z - 3 * q};
    st = '{upState(uOd), upState(uEv), (modeE ? 21 : 42), upState(uEv), upState(uOd), 42,
           loState(lOd), loState(lEv), (modeE ? 63 : 42), loState(lEv), loState(lOd), 42};
    for (int s = 0; s < 12; s++)
      for (int n = 0; n < d[s]; n++) begin
        expQ.push_back(st[s]);
        segQ.push_back(s);
      end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started = 0;
      satE = 0;
      expQ.delete();
      segQ.delete();
    end else begin
      if (started) begin
        void'(expQ.pop_front());
        void'(segQ.pop_front());
      end
      if (!started || expQ.size() == 0) begin
        buildPeriod();
        started = 1;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", req, what, act, expv, $time);
    end
  endtask

  function automatic string segTag(int s, bit m);
    if (s < 0) return "R2";
    if (s == 2 || s == 5 || s == 8 || s == 11) return m ? "R3 R7 R8" : "R3 R6 R8";
    return "R3 R4 R8";
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      int expv, seg, topN, botN, outN;
      int eU, eM, eL;
      expv = started ? expQ[0] : 42;
      seg  = started ? segQ[0] : -1;
      check(legState == 6'(expv), {tagNow, " ", segTag(seg, modeE)}, "legState", legState, expv);
      eU = 0; eM = 0; eL = 0;
      for (int g = 0; g < 3; g++) begin
        int c;
        c = (expv >> (2 * g)) & 3;
        eU |= (c != 3) << g;
        eM |= (c != 2) << g;
        eL |= (c != 1) << g;
      end
      check({gateUpper, gateMid, gateLower} == 9'((eU << 6) | (eM << 3) | eL), "R1", "gates",
            {gateUpper, gateMid, gateLower}, (eU << 6) | (eM << 3) | eL);
      check(satFlag == satE, {tagNow, " R9"}, "satFlag", satFlag, satE);
      topN = 0; botN = 0; outN = 0;
      for (int g = 0; g < 3; g++) begin
        if (legState[2*g +: 2] == 2'b01) topN++;
        if (legState[2*g +: 2] == 2'b11) botN++;
        if (legState[2*g +: 2] == 2'b10) outN++;
      end
      check(!(topN > 0 && botN > 0), "R5", "both outputs active", legState, 0);
      if (seg >= 0 && !(seg == 2 || seg == 5 || seg == 8 || seg == 11))
        check(outN == 1 || outN == 2, "R12", "outer-pair legs in active segment", outN, 12);
    end
  end

  // ---------------- stimulus ----------------
  task automatic setIn(int su, int sl, int a, int b, int c, int d, int tp, bit m);
    upSector = 3'(su); loSector = 3'(sl);
    dwellT1 = DW'(a); dwellT2 = DW'(b); dwellT3 = DW'(c); dwellT4 = DW'(d);
    periodLen = DW'(tp); lowDistortion = m;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    setIn(0, 0, 0, 0, 0, 0, 12, 0);
    waitCycles(3);                         // R2: reset state observed
    rst_n = 1'b1;
    tagNow = "R3 R6";
    setIn(0, 3, 10, 6, 8, 4, 60, 0);
    waitCycles(130);
    tagNow = "R7";
    setIn(0, 3, 10, 6, 8, 4, 60, 1);
    waitCycles(130);
    tagNow = "R4";
    for (int s = 0; s < 6; s++) begin
      setIn(s, (2 * s + 1) % 6, 7 + s, 5, 9, 3 + s, 48, s % 2);
      waitCycles(100);
    end
    tagNow = "R9";
    setIn(1, 4, 30, 20, 25, 15, 50, 0);
    waitCycles(110);
    setIn(2, 5, 40, 40, 40, 41, 37, 1);
    waitCycles(80);
    tagNow = "R8";
    setIn(3, 2, 0, 0, 0, 0, 13, 0);
    waitCycles(30);
    setIn(4, 1, 5, 0, 7, 0, 17, 1);
    waitCycles(40);
    setIn(5, 0, 1, 1, 1, 1, 1, 0);
    waitCycles(10);
    setIn(1, 1, 3, 3, 3, 3, 15, 1);
    waitCycles(35);
    tagNow = "R11";
    setIn(6, 7, 9, 4, 6, 2, 40, 0);
    waitCycles(90);
    setIn(7, 6, 3, 8, 5, 7, 41, 1);
    waitCycles(90);
    tagNow = "R10";
    setIn(2, 2, 8, 8, 8, 8, 64, 0);
    waitCycles(20);
    setIn(0, 5, 1, 2, 3, 4, 64, 1);      // mid-period change
    waitCycles(10);
    setIn(4, 3, 20, 1, 2, 30, 33, 0);    // another mid-period change
    waitCycles(150);
    tagNow = "R2";
    @(posedge clk);
    #1 rst_n = 1'b0;                     // reset in the middle of a period
    waitCycles(3);
    rst_n = 1'b1;
    waitCycles(40);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule